// File: doc/BRIEF.md
# Free-Running Timer with Input Capture

This block is a 16-bit up-counter that advances on a clock-enable input and wraps from 0xFFFF to 0x0000. It has two compare channels, a capture channel fed by an external pin, an interrupt-enable byte, an edge-select control bit and a status byte. Each compare channel matches when the counter equals its register. The capture channel stores the counter value when the selected edge of the pin is seen. Each of the four events (capture, compare A, compare B, wrap) sets a sticky status flag. Each flag drives an interrupt request that is gated by its enable bit.

All registers sit on an 8-bit bus with separate read and write strobes. Read data is registered and appears one cycle after the read strobe. Sixteen-bit values pass through one shared byte latch, so a byte-at-a-time access sees or commits a consistent 16-bit value. Software clears a flag by writing 0 to it, but only after it has read that flag as 1. A synchronous `standby` input returns all register state to its reset values, as `rst` does.

Register addresses: 0x0 interrupt enable, 0x1 status, 0x2 control (bit 0: 1 = rising edge, 0 = falling edge), 0x4/0x5 counter high/low, 0x6/0x7 compare A high/low, 0x8/0x9 compare B high/low, 0xA/0xB capture high/low. The status and enable bytes share bit positions: bit 7 capture, bit 3 compare A, bit 2 compare B, bit 1 wrap.

Top module: `frt_capture_timer`

## Requirements
- R1: After reset the enable byte reads 0x01, status reads 0x00, the counter reads 0x0000, both compare registers read 0xFFFF and the capture register reads 0x0000.
- R2: Enable bits 7, 3, 2 and 1 are writable; bits 6 to 4 always read 0 and bit 0 always reads 1.
- R3: Reading a high byte returns it and latches that register's low byte; the next low-byte read returns the latched byte even if the counter has moved since.
- R4: A high-byte write only fills the shared latch and leaves the target unchanged; the low-byte write commits {latch, low byte} to the target in one step.
- R5: The counter rises by one on each cycle with `cnt_en` high and holds otherwise; a step from 0xFFFF to 0x0000 sets status bit 1.
- R6: While the counter equals compare A, status bit 3 is set; while it equals compare B, status bit 2 is set.
- R7: The selected edge of `cap_pin` (control bit 0: 1 rising, 0 falling) copies the counter into the capture register and sets status bit 7 on the third clock edge after the pin changes; the other edge does nothing; pulses of six clocks or more are captured.
- R8: Writing 0 to a status bit clears it only if that bit was read as 1 since it was last set; writing 1 to it, or writing 0 without such a read, leaves it set.
- R9: When a flag's set event and its clear fall in the same cycle, the flag stays set.
- R10: Each interrupt output is high exactly when its flag and its enable bit are both 1.
- R11: A one-cycle `standby` pulse restores every register to its R1 value.
- R12: Writes to the capture addresses leave the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Synchronous state reset for standby entry |
| cnt_en | input | 1 | Counter advance enable |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one cycle after the read strobe |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Counter wrap interrupt request |

## Verification
The assertions assume that the read and write strobes never fire in the same cycle. They also assume that the capture pin holds each level for at least six clocks, so the synchronizer never skips an edge. The stimulus drives every input at the falling clock edge and issues each bus access as a single one-cycle strobe. It holds every capture pulse for six clocks or longer. Tests that need an exact captured value stop the counter, or start it on a known edge, so that the counter value at the capture edge is known.

// File: rtl/frt_pkg.sv
package frt_pkg;

  localparam int ADDR_W    = 4;
  localparam int NUM_FLAGS = 4;
  localparam int NUM_CMP   = 2;

  localparam logic [ADDR_W-1:0] A_IER    = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h2;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'h5;
  localparam logic [ADDR_W-1:0] A_CMPA_H = 4'h6;
  localparam logic [ADDR_W-1:0] A_CMPA_L = 4'h7;
  localparam logic [ADDR_W-1:0] A_CMPB_H = 4'h8;
  localparam logic [ADDR_W-1:0] A_CMPB_L = 4'h9;
  localparam logic [ADDR_W-1:0] A_CAP_H  = 4'hA;
  localparam logic [ADDR_W-1:0] A_CAP_L  = 4'hB;

  localparam logic [7:0] IER_WMASK = 8'h8E;
  localparam logic [7:0] IER_ONES  = 8'h01;

  // flag index: 0 capture, 1 compare A, 2 compare B, 3 wrap
  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return 7;
      1:       return 3;
      2:       return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/frt_sync_edge.sv
module frt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic edge_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur        = sync_q[STAGES-1];
  assign edge_pulse = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !edge_pulse); // R7

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int W     = 16,
  parameter int N_CMP = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      load,
  input  logic [W-1:0]              load_val,
  input  logic [N_CMP-1:0][W-1:0]   cmp_val,
  output logic [W-1:0]              cnt_q,
  output logic                      wrap_evt,
  output logic [N_CMP-1:0]          match
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (en)   cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_evt = en && !load && (cnt_q == ALL_ONES);

  for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
    assign match[gi] = (cnt_q == cmp_val[gi]);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt_q)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/frt_flag.sv
module frt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic arm_req,
  input  logic clr_req,
  output logic flag_q,
  output logic armed_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_evt) begin
      flag_q  <= 1'b1;
      if (arm_req && flag_q) armed_q <= 1'b1;
    end else if (clr_req && armed_q) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_req && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q); // R9
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    ($fell(flag_q) && !$past(rst)) |-> $past(armed_q)); // R8

endmodule

// File: rtl/frt_capture_timer.sv
module frt_capture_timer
  import frt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              cnt_en,
  input  logic              cap_pin,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_cap,
  output logic              irq_cmpa,
  output logic              irq_cmpb,
  output logic              irq_ovf
);

  localparam int CNT_W = 2 * DATA_W;

  logic                           clr;
  logic [DATA_W-1:0]              ier_q;
  logic [DATA_W-1:0]              ier_view;
  logic                           rise_sel_q;
  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]               cap_q;
  logic [DATA_W-1:0]              temp_q;
  logic [DATA_W-1:0]              rdata_q;
  logic [CNT_W-1:0]               cnt;
  logic                           wrap_evt;
  logic [NUM_CMP-1:0]             match;
  logic                           cap_evt;
  logic                           cnt_load;
  logic                           stat_rd;
  logic                           stat_wr;
  logic [NUM_FLAGS-1:0]           set_vec;
  logic [NUM_FLAGS-1:0]           flag_vec;
  logic [NUM_FLAGS-1:0]           arm_vec;
  logic [NUM_FLAGS-1:0]           en_vec;
  logic [DATA_W-1:0]              stat_view;

  assign clr      = rst | standby;
  assign cnt_load = bus_wr && (bus_addr == A_CNT_L);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign stat_wr  = bus_wr && (bus_addr == A_STAT);

  frt_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (clr),
    .din        (cap_pin),
    .rise_sel   (rise_sel_q),
    .edge_pulse (cap_evt)
  );

  frt_counter #(.W(CNT_W), .N_CMP(NUM_CMP)) u_cnt (
    .clk      (clk),
    .rst      (clr),
    .en       (cnt_en),
    .load     (cnt_load),
    .load_val ({temp_q, bus_wdata}),
    .cmp_val  (cmp_q),
    .cnt_q    (cnt),
    .wrap_evt (wrap_evt),
    .match    (match)
  );

  assign set_vec = {wrap_evt, match[1], match[0], cap_evt};

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    frt_flag u_flag (
      .clk     (clk),
      .rst     (clr),
      .set_evt (set_vec[gi]),
      .arm_req (stat_rd),
      .clr_req (stat_wr && !bus_wdata[flag_pos(gi)]),
      .flag_q  (flag_vec[gi]),
      .armed_q (arm_vec[gi])
    );
    assign en_vec[gi] = ier_q[flag_pos(gi)];
  end

  always_comb begin
    stat_view = '0;
    for (int i = 0; i < NUM_FLAGS; i++) stat_view[flag_pos(i)] = flag_vec[i];
  end

  assign ier_view = ier_q | IER_ONES;

  // capture register
  always_ff @(posedge clk) begin
    if (clr)          cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end

  // register writes and registered reads through the shared byte latch
  always_ff @(posedge clk) begin
    if (clr) begin
      ier_q      <= '0;
      rise_sel_q <= 1'b0;
      cmp_q      <= '1;
      temp_q     <= '0;
      rdata_q    <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_IER:    ier_q      <= bus_wdata & IER_WMASK;
          A_CTRL:   rise_sel_q <= bus_wdata[0];
          A_CNT_H,
          A_CMPA_H,
          A_CMPB_H: temp_q     <= bus_wdata;
          A_CMPA_L: cmp_q[0]   <= {temp_q, bus_wdata};
          A_CMPB_L: cmp_q[1]   <= {temp_q, bus_wdata};
          default:  ;
        endcase
      end
      if (bus_rd) begin
        case (bus_addr)
          A_IER:  rdata_q <= ier_view;
          A_STAT: rdata_q <= stat_view;
          A_CTRL: rdata_q <= {{(DATA_W-1){1'b0}}, rise_sel_q};
          A_CNT_H: begin
            rdata_q <= cnt[CNT_W-1:DATA_W];
            temp_q  <= cnt[DATA_W-1:0];
          end
          A_CMPA_H: begin
            rdata_q <= cmp_q[0][CNT_W-1:DATA_W];
            temp_q  <= cmp_q[0][DATA_W-1:0];
          end
          A_CMPB_H: begin
            rdata_q <= cmp_q[1][CNT_W-1:DATA_W];
            temp_q  <= cmp_q[1][DATA_W-1:0];
          end
          A_CAP_H: begin
            rdata_q <= cap_q[CNT_W-1:DATA_W];
            temp_q  <= cap_q[DATA_W-1:0];
          end
          A_CNT_L, A_CMPA_L, A_CMPB_L, A_CAP_L: rdata_q <= temp_q;
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_cap   = flag_vec[0] & en_vec[0];
  assign irq_cmpa  = flag_vec[1] & en_vec[1];
  assign irq_cmpb  = flag_vec[2] & en_vec[2];
  assign irq_ovf   = flag_vec[3] & en_vec[3];

  AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (clr)
    !cap_evt |=> $stable(cap_q)); // R12
  AST_IER_FIXED_BITS: assert property (@(posedge clk) disable iff (clr)
    (bus_rd && bus_addr == A_IER) |=> (bus_rdata[0] && bus_rdata[6:4] == 3'b000)); // R2
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (clr)
    !(bus_rd && bus_wr)); // R3

endmodule

// File: tb/tb_frt_capture_timer.sv
module tb_frt_capture_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       standby = 1'b0;
  logic       cnt_en = 1'b0;
  logic       cap_pin = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_cap, irq_cmpa, irq_cmpb, irq_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frt_capture_timer dut (
    .clk(clk), .rst(rst), .standby(standby), .cnt_en(cnt_en), .cap_pin(cap_pin),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_cap(irq_cap), .irq_cmpa(irq_cmpa),
    .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr16(input logic [3:0] ah, input logic [15:0] v);
    wr(ah, v[15:8]);
    wr(ah + 4'd1, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] ah, output logic [15:0] v);
    logic [7:0] h, l;
    rd(ah, h);
    rd(ah + 4'd1, l);
    v = {h, l};
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [15:0] w;
    rd(4'h0, b);  check("R1 ier", b, 8'h01);
    rd(4'h1, b);  check("R1 status", b, 8'h00);
    rd16(4'h4, w); check("R1 counter", w, 16'h0000);
    rd16(4'h6, w); check("R1 cmpA", w, 16'hFFFF);
    rd16(4'h8, w); check("R1 cmpB", w, 16'hFFFF);
    rd16(4'hA, w); check("R1 capture", w, 16'h0000);
  endtask

  task automatic t_ier();
    logic [7:0] b;
    wr(4'h0, 8'hFF); rd(4'h0, b); check("R2 ier all ones", b, 8'h8F);
    wr(4'h0, 8'h00); rd(4'h0, b); check("R2 ier zero", b, 8'h01);
  endtask

  task automatic t_wr16();
    logic [15:0] w;
    wr16(4'h6, 16'h1000); rd16(4'h6, w); check("R4 cmpA commit", w, 16'h1000);
    wr(4'h8, 8'h77); rd16(4'h8, w); check("R4 high write alone", w, 16'hFFFF);
    wr16(4'h8, 16'h2000); rd16(4'h8, w); check("R4 cmpB commit", w, 16'h2000);
  endtask

  task automatic t_rd16();
    logic [7:0] h, l; logic [15:0] w;
    wr16(4'h4, 16'h34FE);
    rd(4'h4, h); check("R3 high byte", h, 8'h34);
    @(negedge clk); cnt_en = 1'b1;
    wait_cyc(5); cnt_en = 1'b0;
    rd(4'h5, l); check("R3 latched low", l, 8'hFE);
    rd16(4'h4, w); check("R3 counter moved", w, 16'h3503);
  endtask

  task automatic t_wrap();
    logic [7:0] b; logic [15:0] w;
    wr16(4'h4, 16'hFFFD);
    @(negedge clk); cnt_en = 1'b1;
    wait_cyc(3); cnt_en = 1'b0;
    rd16(4'h4, w); check("R5 wrapped counter", w, 16'h0000);
    rd(4'h1, b); check("R5 wrap flag", b, 8'h02);
    check("R10 ovf masked", irq_ovf, 0);
    wr(4'h0, 8'h02); check("R10 ovf enabled", irq_ovf, 1);
    wr(4'h1, 8'hFF); rd(4'h1, b); check("R8 write one ignored", b, 8'h02);
    wr(4'h1, 8'h00); rd(4'h1, b); check("R8 clear after read", b, 8'h00);
    check("R10 ovf low after clear", irq_ovf, 0);
    wr16(4'h4, 16'hFFFF);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    wr(4'h1, 8'h00); rd(4'h1, b); check("R8 clear without read", b, 8'h02);
    wr(4'h1, 8'h00); rd(4'h1, b); check("R8 clear once read", b, 8'h00);
  endtask

  task automatic t_compare();
    logic [7:0] b;
    wr16(4'h4, 16'h0FFE);
    @(negedge clk); cnt_en = 1'b1;
    wait_cyc(2); cnt_en = 1'b0;
    rd(4'h1, b); check("R6 compare A flag", b, 8'h08);
    check("R10 cmpa masked", irq_cmpa, 0);
    wr(4'h0, 8'h08); check("R10 cmpa enabled", irq_cmpa, 1);
    wr16(4'h4, 16'h0000);
    wr(4'h1, 8'h00); rd(4'h1, b); check("R6 compare A cleared", b, 8'h00);
    wr16(4'h4, 16'h2000);
    rd(4'h1, b); check("R6 compare B flag", b, 8'h04);
    wr(4'h0, 8'h04);
    check("R10 cmpb enabled", irq_cmpb, 1);
    check("R10 cmpa off", irq_cmpa, 0);
    wr16(4'h4, 16'h0000);
    wr(4'h1, 8'h00); rd(4'h1, b); check("R6 compare B cleared", b, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] b;
    wr16(4'h4, 16'h1000);
    rd(4'h1, b); check("R9 flag set", b, 8'h08);
    wr(4'h1, 8'h00); rd(4'h1, b); check("R9 set beats clear", b, 8'h08);
    wr16(4'h4, 16'h0000);
    wr(4'h1, 8'h00); rd(4'h1, b); check("R9 later clear", b, 8'h00);
  endtask

  task automatic t_capture();
    logic [7:0] b; logic [15:0] w;
    wr(4'h0, 8'h80); wr(4'h2, 8'h01);
    wr16(4'h4, 16'h4321);
    @(negedge clk); cap_pin = 1'b1;
    wait_cyc(4);
    wr16(4'h4, 16'h5555);
    cap_pin = 1'b0;
    wait_cyc(5);
    rd16(4'hA, w); check("R7 rising capture", w, 16'h4321);
    rd(4'h1, b); check("R7 capture flag", b, 8'h80);
    check("R10 cap irq", irq_cap, 1);
    wr(4'h1, 8'h00);
    wr(4'h2, 8'h00);
    @(negedge clk); cap_pin = 1'b1;
    wait_cyc(6);
    rd(4'h1, b); check("R7 rise ignored in falling mode", b, 8'h00);
    cap_pin = 1'b0;
    wait_cyc(5);
    rd16(4'hA, w); check("R7 falling capture", w, 16'h5555);
    rd(4'h1, b); check("R7 falling flag", b, 8'h80);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_latency();
    logic [15:0] w;
    wr(4'h2, 8'h01);
    wr16(4'h4, 16'h0000);
    @(negedge clk); cap_pin = 1'b1; cnt_en = 1'b1;
    wait_cyc(6); cnt_en = 1'b0; cap_pin = 1'b0;
    wait_cyc(4);
    rd16(4'hA, w); check("R7 third-edge latency, six-clock pulse", w, 16'h0002);
  endtask

  task automatic t_ro();
    logic [15:0] w;
    wr(4'hA, 8'hAA); wr(4'hB, 8'hBB);
    rd16(4'hA, w); check("R12 capture read-only", w, 16'h0002);
  endtask

  task automatic t_standby();
    logic [7:0] b; logic [15:0] w;
    wr(4'h0, 8'hFF);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    rd(4'h0, b);  check("R11 ier", b, 8'h01);
    rd(4'h1, b);  check("R11 status", b, 8'h00);
    rd16(4'h4, w); check("R11 counter", w, 16'h0000);
    rd16(4'h6, w); check("R11 cmpA", w, 16'hFFFF);
    rd16(4'h8, w); check("R11 cmpB", w, 16'hFFFF);
    rd16(4'hA, w); check("R11 capture", w, 16'h0000);
    check("R11 irqs", {irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    t_reset();
    t_ier();
    t_wr16();
    t_rd16();
    t_wrap();
    t_compare();
    t_set_wins();
    t_capture();
    t_latency();
    t_ro();
    t_standby();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule